// File: doc/BRIEF.md
# Asynchronous SRAM Page-Mode Controller

This block lets a clocked host talk to an external asynchronous static RAM. The host places one request at a time on a small request port: a single-word write, a single random read, or a burst read of several consecutive words. The controller then drives the full address bus, which is not multiplexed, together with three active-low strobes: chip select, write strobe and output strobe. It also drives write data onto the shared data bus through a separate drive enable, and it captures read data from that bus. No clock and no refresh command go to the memory.

Every wait is counted in clock cycles. The counts are worked out during elaboration from nanosecond timing parameters and the clock period, rounding up. A burst read keeps chip select low and steps the address by one for each word. While a step stays inside the same aligned page, where only the low address bits change, the memory returns the next word sooner, so the controller waits the short page count. The first word, and any step into a new page, waits the full random-access count. A write holds the address and data steady for one cycle, pulses the write strobe, and then keeps the data on the bus for one more cycle before it lets go.

Top module: `asram_page_ctrl`

## Requirements
- R1: During and right after reset, all three strobes are high (inactive), the data drive enable is low, `ready` is high, and `rdata_valid` and `done` are low.
- R2: The wait counts are ceil(ns / CLK_NS), never less than 1. With the default values this gives 7 cycles for a random read, 3 for a page read and 2 for the write pulse. A read request is accepted on a clock edge where `ready` and `req` are high and `req_we` is 0. Its first word appears on `rdata` with a one-cycle `rdata_valid` pulse exactly RD_CYC edges after the accepting edge, and it is the memory contents at `req_addr`.
- R3: A burst read returns `req_len`+1 words from consecutive addresses. A word whose address stays in the page of the word before it, meaning the bits above the low PAGE_W bits are unchanged, follows that word after PG_CYC edges.
- R4: A step out of a page happens when the low PAGE_W bits of the previous address are all ones. The word after such a step waits the full RD_CYC edges. The address wraps from the top of the array to 0.
- R5: In a write, the address, data and drive enable appear on the accepting edge with chip select low. The write strobe goes low one edge later and stays low for WP_CYC cycles, and the address and data stay stable during that time. The drive enable falls one edge after the write strobe rises.
- R6: A write always stores exactly one word, whatever the value of `req_len`.
- R7: The drive enable is never high while the output strobe is low, and the write strobe and output strobe are never low together.
- R8: The write strobe, the output strobe and the drive enable are active only while chip select is low. `ready` is low whenever chip select is low.
- R9: `done` pulses for one cycle when a transaction ends: together with the last read word, or on the edge where a write releases the bus. `ready` is high again from that same edge onward.
- R10: A `req` that arrives while `ready` is low is ignored. It does not start a transaction or change the memory.
- R11: Read data is sampled only while the output strobe is low, and only after the current address has been held for at least PG_CYC cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req | input | 1 | Request strobe, taken only while `ready` is high |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Start address |
| req_wdata | input | DATA_W | Write data |
| req_len | input | LEN_W | Extra words in a burst read (words = value + 1) |
| ready | output | 1 | Controller idle, able to take a request |
| rdata | output | DATA_W | Captured read word |
| rdata_valid | output | 1 | One-cycle pulse per read word |
| done | output | 1 | One-cycle pulse at the end of a transaction |
| mem_addr | output | ADDR_W | Memory address bus |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output strobe, active low |
| mem_dq_o | output | DATA_W | Data driven toward the memory |
| mem_dq_oe | output | 1 | Drive enable for the data bus pad |
| mem_dq_i | input | DATA_W | Data arriving from the memory |

## Verification
The assertions assume that the host only raises `req` with stable request fields, and that the memory returns valid data only after its access time for the address currently applied. They also assume that any value on the bus before that time is wrong and is never used. The bench's memory model makes that second assumption real. It returns inverted data until the right number of cycles have passed for the current address, and it grants the short page time only when chip select stayed low and the upper address bits did not change. Stimulus always waits for `ready` before issuing a request. The only exception is deliberate: extra requests are driven while the controller is busy, to show that they have no effect.

// File: rtl/asram_pkg.sv
package asram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD,
    ST_WSET,
    ST_WPULSE,
    ST_WHOLD
  } ctrl_st_e;

  // Round a duration up to whole clock cycles, never less than one.
  function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned per);
    int unsigned c;
    c = (ns + per - 1) / per;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/asram_wait_timer.sv
// Down-counter for wait states; expire marks the edge on which the wait ends.
module asram_wait_timer #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expire
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (cnt != '0) begin
      cnt <= cnt - CNT_W'(1);
    end
  end

  assign expire = (cnt == CNT_W'(1));

endmodule

// File: rtl/asram_page_step.sv
// Next burst address and the wait that address will need.
module asram_page_step #(
  parameter int          ADDR_W = 11,
  parameter int          PAGE_W = 2,
  parameter int          CNT_W  = 3,
  parameter int unsigned RD_CYC = 7,
  parameter int unsigned PG_CYC = 3
) (
  input  logic [ADDR_W-1:0] cur_addr,
  output logic [ADDR_W-1:0] nxt_addr,
  output logic [CNT_W-1:0]  nxt_wait
);

  assign nxt_addr = cur_addr + ADDR_W'(1);

  generate
    if (PAGE_W == 0) begin : g_no_page
      assign nxt_wait = CNT_W'(RD_CYC);
    end else begin : g_page
      logic leaves_page;
      assign leaves_page = &cur_addr[PAGE_W-1:0];
      assign nxt_wait    = leaves_page ? CNT_W'(RD_CYC) : CNT_W'(PG_CYC);
    end
  endgenerate

endmodule

// File: rtl/asram_page_ctrl.sv
module asram_page_ctrl
  import asram_pkg::*;
#(
  parameter int ADDR_W    = 11,
  parameter int DATA_W    = 8,
  parameter int LEN_W     = 4,
  parameter int PAGE_W    = 2,
  parameter int CLK_NS    = 10,
  parameter int T_RAND_NS = 70,
  parameter int T_PAGE_NS = 30,
  parameter int T_WE_NS   = 15,
  parameter int T_EDGE_NS = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [LEN_W-1:0]  req_len,
  output logic              ready,
  output logic [DATA_W-1:0] rdata,
  output logic              rdata_valid,
  output logic              done,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_i
);

  localparam int unsigned RD_CYC  = ns_to_cyc(T_RAND_NS, CLK_NS);
  localparam int unsigned PG_CYC  = ns_to_cyc(T_PAGE_NS, CLK_NS);
  localparam int unsigned WP_CYC  = ns_to_cyc(T_WE_NS + T_EDGE_NS, CLK_NS);
  localparam int unsigned MAX_CYC = max2(max2(RD_CYC, PG_CYC), WP_CYC);
  localparam int          CNT_W   = $clog2(MAX_CYC + 1);

  ctrl_st_e          st;
  logic [LEN_W-1:0]  left;
  logic              tmr_load;
  logic [CNT_W-1:0]  tmr_val;
  logic              tmr_exp;
  logic [ADDR_W-1:0] nxt_addr;
  logic [CNT_W-1:0]  nxt_wait;

  asram_page_step #(
    .ADDR_W (ADDR_W),
    .PAGE_W (PAGE_W),
    .CNT_W  (CNT_W),
    .RD_CYC (RD_CYC),
    .PG_CYC (PG_CYC)
  ) u_step (
    .cur_addr (mem_addr),
    .nxt_addr (nxt_addr),
    .nxt_wait (nxt_wait)
  );

  asram_wait_timer #(
    .CNT_W (CNT_W)
  ) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expire   (tmr_exp)
  );

  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = nxt_wait;
    unique case (st)
      ST_IDLE: begin
        tmr_load = req && !req_we;
        tmr_val  = CNT_W'(RD_CYC);
      end
      ST_RD: begin
        tmr_load = tmr_exp && (left != '0);
        tmr_val  = nxt_wait;
      end
      ST_WSET: begin
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(WP_CYC);
      end
      default: begin
        tmr_load = 1'b0;
        tmr_val  = nxt_wait;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= ST_IDLE;
      left        <= '0;
      mem_addr    <= '0;
      mem_ce_n    <= 1'b1;
      mem_we_n    <= 1'b1;
      mem_oe_n    <= 1'b1;
      mem_dq_o    <= '0;
      mem_dq_oe   <= 1'b0;
      rdata       <= '0;
      rdata_valid <= 1'b0;
      done        <= 1'b0;
    end else begin
      rdata_valid <= 1'b0;
      done        <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (req) begin
            mem_addr <= req_addr;
            mem_ce_n <= 1'b0;
            left     <= req_len;
            if (req_we) begin
              mem_dq_o  <= req_wdata;
              mem_dq_oe <= 1'b1;
              st        <= ST_WSET;
            end else begin
              mem_oe_n <= 1'b0;
              st       <= ST_RD;
            end
          end
        end
        ST_RD: begin
          if (tmr_exp) begin
            rdata       <= mem_dq_i;
            rdata_valid <= 1'b1;
            if (left == '0) begin
              mem_ce_n <= 1'b1;
              mem_oe_n <= 1'b1;
              done     <= 1'b1;
              st       <= ST_IDLE;
            end else begin
              left     <= left - LEN_W'(1);
              mem_addr <= nxt_addr;
            end
          end
        end
        ST_WSET: begin
          mem_we_n <= 1'b0;
          st       <= ST_WPULSE;
        end
        ST_WPULSE: begin
          if (tmr_exp) begin
            mem_we_n <= 1'b1;
            st       <= ST_WHOLD;
          end
        end
        ST_WHOLD: begin
          mem_dq_oe <= 1'b0;
          mem_ce_n  <= 1'b1;
          done      <= 1'b1;
          st        <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign ready = (st == ST_IDLE);

endmodule

// File: rtl/asram_page_ctrl_chk.sv
module asram_page_ctrl_chk
  import asram_pkg::*;
#(
  parameter int ADDR_W    = 11,
  parameter int DATA_W    = 8,
  parameter int CLK_NS    = 10,
  parameter int T_PAGE_NS = 30
) (
  input logic              clk,
  input logic              rst,
  input logic              ready,
  input logic              rdata_valid,
  input logic              done,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ce_n,
  input logic              mem_we_n,
  input logic              mem_oe_n,
  input logic [DATA_W-1:0] mem_dq_o,
  input logic              mem_dq_oe
);

  localparam int unsigned PG_CYC = ns_to_cyc(T_PAGE_NS, CLK_NS);
  localparam int          AGE_W  = 8;

  // Cycles the present address has been held.
  logic [ADDR_W-1:0] prev_addr;
  logic [AGE_W-1:0]  age;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_addr <= '0;
      age       <= '0;
    end else begin
      prev_addr <= mem_addr;
      if (mem_addr != prev_addr) age <= AGE_W'(1);
      else if (age != '1)        age <= age + AGE_W'(1);
    end
  end

  a_r7_no_drive_clash: assert property (@(posedge clk) disable iff (rst)
    !(mem_dq_oe && !mem_oe_n));

  a_r7_we_oe_excl: assert property (@(posedge clk) disable iff (rst)
    !(!mem_we_n && !mem_oe_n));

  a_r8_strobe_needs_ce: assert property (@(posedge clk) disable iff (rst)
    (!mem_we_n || !mem_oe_n || mem_dq_oe) |-> !mem_ce_n);

  a_r8_busy_when_selected: assert property (@(posedge clk) disable iff (rst)
    !mem_ce_n |-> !ready);

  a_r5_stable_during_we: assert property (@(posedge clk) disable iff (rst)
    (!mem_we_n && !$past(mem_we_n)) |-> ($stable(mem_addr) && $stable(mem_dq_o)));

  a_r5_release_after_we: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we_n) |-> mem_dq_oe ##1 !mem_dq_oe);

  a_r9_done_one_cycle: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r11_sample_window: assert property (@(posedge clk) disable iff (rst)
    rdata_valid |-> ((age >= AGE_W'(PG_CYC)) && !$past(mem_oe_n)));

endmodule

bind asram_page_ctrl asram_page_ctrl_chk #(
  .ADDR_W    (ADDR_W),
  .DATA_W    (DATA_W),
  .CLK_NS    (CLK_NS),
  .T_PAGE_NS (T_PAGE_NS)
) u_chk (.*);

// File: tb/asram_page_ctrl_bench.sv
module asram_page_ctrl_bench;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 11;
  localparam int DW = 8;
  localparam int LW = 4;
  localparam int PW = 2;
  localparam int RD_W = (70 + CLK_PERIOD - 1) / CLK_PERIOD;
  localparam int PG_W = (30 + CLK_PERIOD - 1) / CLK_PERIOD;
  localparam int WP_W = (15 + 5 + CLK_PERIOD - 1) / CLK_PERIOD;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req = 1'b0;
  logic          req_we = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic [LW-1:0] req_len = '0;
  logic          ready, rdata_valid, done;
  logic [DW-1:0] rdata;
  logic [AW-1:0] mem_addr;
  logic          mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [DW-1:0] mem_dq_o, mem_dq_i;

  always #(CLK_PERIOD / 2) clk = ~clk;

  asram_page_ctrl u_asram_page_ctrl (
    .clk(clk), .rst(rst), .req(req), .req_we(req_we), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_len(req_len), .ready(ready), .rdata(rdata),
    .rdata_valid(rdata_valid), .done(done), .mem_addr(mem_addr),
    .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
  );

  // Behavioural memory: wrong (inverted) data until the access time has elapsed.
  logic [DW-1:0] sram   [2**AW];
  logic [DW-1:0] shadow [2**AW];
  logic [AW-1:0] last_addr = '0;
  logic          last_ce_n = 1'b1;
  logic          last_we_n = 1'b1;
  int            held = 0;
  bit            page_hit = 1'b0;

  always @(negedge clk) begin
    if (!last_we_n && mem_we_n && !mem_ce_n && mem_dq_oe) sram[mem_addr] = mem_dq_o;
    if (mem_addr != last_addr || (last_ce_n && !mem_ce_n)) begin
      page_hit = !last_ce_n && !mem_ce_n && (mem_addr[AW-1:PW] == last_addr[AW-1:PW]);
      held = 0;
    end else begin
      held = held + 1;
    end
    last_addr = mem_addr;
    last_ce_n = mem_ce_n;
    last_we_n = mem_we_n;
  end

  assign mem_dq_i = (!mem_ce_n && !mem_oe_n && (held + 1 >= (page_hit ? PG_W : RD_W)))
                    ? sram[mem_addr] : ~sram[mem_addr];

  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d, input int len);
    @(negedge clk);
    chk(ready == 1'b1, "R9 ready before write", ready, 1);
    req = 1'b1; req_we = 1'b1; req_addr = a; req_wdata = d; req_len = LW'(len);
    @(negedge clk);
    req = 1'b0;
    for (int t = 0; t <= WP_W + 3; t++) begin
      if (t <= WP_W + 1) begin
        chk(mem_we_n == !(t >= 1 && t <= WP_W), "R5 write strobe", mem_we_n, !(t >= 1 && t <= WP_W));
        chk(mem_dq_oe == 1'b1, "R5 drive enable held", mem_dq_oe, 1);
        chk(mem_addr == a && mem_dq_o == d, "R5 address/data", mem_addr, a);
        chk(mem_ce_n == 1'b0 && mem_oe_n == 1'b1, "R8 strobes in write", {mem_ce_n, mem_oe_n}, 1);
        chk(done == 1'b0 && ready == 1'b0, "R9 busy in write", {done, ready}, 0);
      end else if (t == WP_W + 2) begin
        chk(mem_dq_oe == 1'b0, "R5 drive released", mem_dq_oe, 0);
        chk(done == 1'b1 && ready == 1'b1, "R9 write done", {done, ready}, 3);
        chk(mem_ce_n == 1'b1, "R8 chip select off", mem_ce_n, 1);
      end else begin
        chk(done == 1'b0 && mem_we_n == 1'b1 && mem_ce_n == 1'b1, "R6 single word", {done, mem_we_n, mem_ce_n}, 3);
      end
      if (t < WP_W + 3) @(negedge clk);
    end
    shadow[a] = d;
  endtask

  task automatic do_read(input logic [AW-1:0] a0, input int len, input bit poke);
    logic [AW-1:0] a;
    int            next_t;
    int            k;
    int            t;
    string         tag;
    @(negedge clk);
    chk(ready == 1'b1, "R9 ready before read", ready, 1);
    req = 1'b1; req_we = 1'b0; req_addr = a0; req_len = LW'(len);
    @(negedge clk);
    req = 1'b0;
    a = a0; next_t = RD_W; k = 0; t = 0; tag = "R2";
    forever begin
      if (poke && t == 1) begin
        req = 1'b1; req_we = 1'b1; req_addr = a0 + AW'(1); req_wdata = 8'hAA; req_len = '0;
      end
      if (poke && t == 2) req = 1'b0;
      if (t == next_t) begin
        chk(rdata_valid == 1'b1, {tag, " word valid"}, rdata_valid, 1);
        chk(rdata == shadow[a], {tag, " word data"}, rdata, shadow[a]);
        chk(done == (k == len), "R9 done with last word", done, k == len);
        chk(ready == (k == len), "R9 ready after last word", ready, k == len);
        chk(mem_oe_n == (k == len), "R8 output strobe", mem_oe_n, k == len);
        if (k == len) break;
        tag = (a[PW-1:0] == '1) ? "R4" : "R3";
        next_t += (a[PW-1:0] == '1) ? RD_W : PG_W;
        a = a + AW'(1);
        k++;
        chk(mem_addr == a, "R3 next address", mem_addr, a);
      end else begin
        chk(rdata_valid == 1'b0, {tag, " no early word"}, rdata_valid, 0);
        chk(done == 1'b0 && ready == 1'b0, "R10 busy", {done, ready}, 0);
        chk(mem_addr == a && mem_oe_n == 1'b0 && mem_ce_n == 1'b0, "R8 read strobes", mem_addr, a);
        chk(mem_we_n == 1'b1 && mem_dq_oe == 1'b0, "R7 no drive in read", {mem_we_n, mem_dq_oe}, 2);
      end
      @(negedge clk);
      t++;
    end
    @(negedge clk);
    chk(rdata_valid == 1'b0 && done == 1'b0 && ready == 1'b1, "R9 idle after read",
        {rdata_valid, done, ready}, 1);
  endtask

  initial begin
    for (int i = 0; i < 2**AW; i++) begin
      sram[i]   = DW'(i * 29 + 3);
      shadow[i] = sram[i];
    end
    repeat (3) @(negedge clk);
    chk(mem_ce_n && mem_we_n && mem_oe_n, "R1 strobes idle", {mem_ce_n, mem_we_n, mem_oe_n}, 7);
    chk(mem_dq_oe == 1'b0 && ready == 1'b1, "R1 bus and ready", {mem_dq_oe, ready}, 1);
    chk(rdata_valid == 1'b0 && done == 1'b0, "R1 no pulses", {rdata_valid, done}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(mem_ce_n && ready, "R1 idle after reset", {mem_ce_n, ready}, 3);

    for (int i = 0; i < 8; i++) do_write(AW'(16 + i), DW'(8'h50 + i * 3), i);  // R6: any length
    do_write(AW'(2**AW - 1), 8'hC3, 15);
    do_write('0, 8'h3C, 0);
    do_read(AW'(19), 0, 1'b0);          // R2 single random read
    do_read(AW'(16), 3, 1'b0);          // R3 whole page
    do_read(AW'(18), 4, 1'b0);          // R4 crossing into next page
    do_read(AW'(2**AW - 2), 2, 1'b0);   // R4 wrap to address 0
    do_read(AW'(20), 2, 1'b1);          // R10 request while busy
    do_read(AW'(21), 0, 1'b0);          // R10 memory unchanged
    do_write(AW'(100), 8'h9E, 7);
    do_read(AW'(97), 5, 1'b0);          // R3/R4 after fresh write
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule